// File: doc/BRIEF.md
# Multi-Slot Mailbox Register File

This block is a register file through which two processor cores pass short messages. It holds a fixed number of slots. Each slot has a mode/status word and a buffer of message words. The sending core fills a slot's buffer and its mode word through the local register port. The peer core reads the message through a separate remote port and then acknowledges the slot.

Each mode word has two fields. A one-hot transfer state sits in bits [7:4], and an acknowledge style bit sits in bit 0. When a remote acknowledge arrives, the slot's state is updated in hardware according to the acknowledge style.

In automatic style the state returns to idle. The sender polls the mode word until it reads idle. In interrupt style the state moves to acknowledged, and a single-cycle event for that slot goes to an external interrupt block. Every other bit of the mode word is plain storage, so software can update either field with a read-modify-write.

Top module: `mbx_regfile`

## Requirements
- R1: Slot n occupies byte offsets 0x40*n to 0x40*n+0x3F. Its mode word is at offset 0x0, and message word k (k = 0..7) is at offset 0x4+4*k.
- R2: A local write to a message word stores all 32 bits. A local read (lcl_req_i=1, lcl_we_i=0) sets lcl_rvalid_o high in the following cycle, with that word on lcl_rdata_o.
- R3: A local write to a mode word stores all 32 bits, and a later read returns them unchanged, including bits outside the state and style fields.
- R4: A remote acknowledge to a slot whose bit 0 is 1 (automatic) sets bits [7:4] to 4'h1 (idle). All other bits are kept, and no event is raised.
- R5: A remote acknowledge to a slot whose bit 0 is 0 (interrupt) sets bits [7:4] to 4'h8 (acknowledged) and keeps all other bits. ack_evt_o[slot] is high for exactly the one cycle after the acknowledge.
- R6: After reset every mode word reads 32'h0000_0010 (idle state, interrupt style), and every message word reads zero.
- R7: Offsets 0x24 to 0x3C inside a slot, and any address whose two low bits are not zero, read as zero. Writes to them change nothing.
- R8: A remote read (rmt_rd_i=1) sets rmt_rvalid_o in the following cycle and returns the same word that a local read of that address returns.
- R9: If a local write to a slot's mode word and a remote acknowledge of the same slot fall in the same cycle, the written value is stored with bits [7:4] replaced by the acknowledge result. That result is chosen by the bit 0 value held before the write.
- R10: At most one bit of ack_evt_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lcl_req_i | input | 1 | Local access strobe |
| lcl_we_i | input | 1 | Local access is a write |
| lcl_addr_i | input | 11 | Local byte address |
| lcl_wdata_i | input | 32 | Local write data |
| lcl_rvalid_o | output | 1 | Local read data valid |
| lcl_rdata_o | output | 32 | Local read data |
| rmt_rd_i | input | 1 | Remote read strobe |
| rmt_addr_i | input | 11 | Remote byte address |
| rmt_rvalid_o | output | 1 | Remote read data valid |
| rmt_rdata_o | output | 32 | Remote read data |
| rmt_ack_i | input | 1 | Remote acknowledge strobe |
| rmt_ack_slot_i | input | 5 | Slot being acknowledged |
| ack_evt_o | output | 32 | Per-slot acknowledge event, one cycle |

## Verification
The bench covers every slot, every in-slot offset, and the misaligned addresses. A decoder with an off-by-one in its data window would make offset 0x24 alias a message word, or lose word 7. A design that rebuilt the mode word from its two fields would lose the stray bits that the read-modify-write test plants. Each slot is acknowledged in the style its own bit 0 selects. If the style were inverted, or the event were held instead of pulsed, the wrong state would read back or ack_evt_o would stay high a second cycle. The same-cycle write and acknowledge case shows whether the acknowledge result is lost under the write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned STATE_LSB    = 4;
  localparam int unsigned ACK_MODE_BIT = 0;
  localparam int unsigned SLOT_BYTES_W = 6;

  typedef enum logic [3:0] {
    ST_IDLE = 4'h1,
    ST_TX   = 4'h2,
    ST_RX   = 4'h4,
    ST_ACKD = 4'h8
  } mbx_state_e;

  localparam logic [31:0] MODE_RST = 32'h0000_0010;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned MSG_WORDS = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned WIDX_W = $clog2(MSG_WORDS),
  localparam int unsigned ADDR_W = SLOT_W + mbx_pkg::SLOT_BYTES_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              is_mode_o,
  output logic              is_data_o,
  output logic [WIDX_W-1:0] widx_o
);
  localparam logic [3:0] LAST_OFF = 4'(MSG_WORDS);

  logic [3:0] off;
  logic       aligned;

  assign off     = addr_i[5:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign slot_o  = addr_i[ADDR_W-1:mbx_pkg::SLOT_BYTES_W];

  always_comb begin
    logic [3:0] rel;
    rel       = off - 4'd1;
    is_mode_o = aligned && (off == 4'd0);
    is_data_o = aligned && (off != 4'd0) && (off <= LAST_OFF);
    widx_o    = rel[WIDX_W-1:0];
  end
endmodule

// File: rtl/mbx_slot_ctrl.sv
module mbx_slot_ctrl #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic [WORD_W-1:0] mode_o,
  output logic              evt_o
);
  import mbx_pkg::*;

  logic [WORD_W-1:0] mode_q, mode_d;
  logic              evt_q;
  logic              auto_ack;

  assign auto_ack = mode_q[ACK_MODE_BIT];

  always_comb begin
    mode_d = wr_i ? wdata_i : mode_q;
    if (ack_i) mode_d[STATE_LSB +: 4] = auto_ack ? ST_IDLE : ST_ACKD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= WORD_W'(MODE_RST);
      evt_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      evt_q  <= ack_i & ~auto_ack;
    end
  end

  assign mode_o = mode_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/mbx_msg_store.sv
module mbx_msg_store #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned MSG_WORDS = 8,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned WIDX_W = $clog2(MSG_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wslot_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [SLOT_W-1:0] ra_slot_i,
  input  logic [WIDX_W-1:0] ra_idx_i,
  output logic [WORD_W-1:0] ra_data_o,
  input  logic [SLOT_W-1:0] rb_slot_i,
  input  logic [WIDX_W-1:0] rb_idx_i,
  output logic [WORD_W-1:0] rb_data_o
);
  logic [WORD_W-1:0] mem_q [NUM_SLOTS][MSG_WORDS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar w = 0; w < MSG_WORDS; w++) begin : g_word
      logic hit;
      assign hit = we_i && (wslot_i == SLOT_W'(s)) && (widx_i == WIDX_W'(w));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  mem_q[s][w] <= '0;
        else if (hit) mem_q[s][w] <= wdata_i;
      end
    end
  end

  assign ra_data_o = mem_q[ra_slot_i][ra_idx_i];
  assign rb_data_o = mem_q[rb_slot_i][rb_idx_i];
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned MSG_WORDS = 8,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W = SLOT_W + mbx_pkg::SLOT_BYTES_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lcl_req_i,
  input  logic                 lcl_we_i,
  input  logic [ADDR_W-1:0]    lcl_addr_i,
  input  logic [WORD_W-1:0]    lcl_wdata_i,
  output logic                 lcl_rvalid_o,
  output logic [WORD_W-1:0]    lcl_rdata_o,
  input  logic                 rmt_rd_i,
  input  logic [ADDR_W-1:0]    rmt_addr_i,
  output logic                 rmt_rvalid_o,
  output logic [WORD_W-1:0]    rmt_rdata_o,
  input  logic                 rmt_ack_i,
  input  logic [SLOT_W-1:0]    rmt_ack_slot_i,
  output logic [NUM_SLOTS-1:0] ack_evt_o
);
  localparam int unsigned WIDX_W = $clog2(MSG_WORDS);

  logic [SLOT_W-1:0] l_slot, r_slot;
  logic              l_is_mode, l_is_data, r_is_mode, r_is_data;
  logic [WIDX_W-1:0] l_widx, r_widx;
  logic [WORD_W-1:0] l_mem_word, r_mem_word;
  logic [WORD_W-1:0] mode_vec [NUM_SLOTS];
  logic              lcl_wr;

  assign lcl_wr = lcl_req_i & lcl_we_i;

  mbx_addr_dec #(.NUM_SLOTS(NUM_SLOTS), .MSG_WORDS(MSG_WORDS)) u_dec_l (
    .addr_i(lcl_addr_i), .slot_o(l_slot), .is_mode_o(l_is_mode),
    .is_data_o(l_is_data), .widx_o(l_widx)
  );

  mbx_addr_dec #(.NUM_SLOTS(NUM_SLOTS), .MSG_WORDS(MSG_WORDS)) u_dec_r (
    .addr_i(rmt_addr_i), .slot_o(r_slot), .is_mode_o(r_is_mode),
    .is_data_o(r_is_data), .widx_o(r_widx)
  );

  mbx_msg_store #(.NUM_SLOTS(NUM_SLOTS), .MSG_WORDS(MSG_WORDS), .WORD_W(WORD_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(lcl_wr && l_is_data), .wslot_i(l_slot), .widx_i(l_widx), .wdata_i(lcl_wdata_i),
    .ra_slot_i(l_slot), .ra_idx_i(l_widx), .ra_data_o(l_mem_word),
    .rb_slot_i(r_slot), .rb_idx_i(r_widx), .rb_data_o(r_mem_word)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    mbx_slot_ctrl #(.WORD_W(WORD_W)) u_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_i(lcl_wr && l_is_mode && (l_slot == SLOT_W'(s))),
      .wdata_i(lcl_wdata_i),
      .ack_i(rmt_ack_i && (rmt_ack_slot_i == SLOT_W'(s))),
      .mode_o(mode_vec[s]),
      .evt_o(ack_evt_o[s])
    );
  end

  logic [WORD_W-1:0] l_word, r_word;

  always_comb begin
    if (l_is_mode)      l_word = mode_vec[l_slot];
    else if (l_is_data) l_word = l_mem_word;
    else                l_word = '0;
    if (r_is_mode)      r_word = mode_vec[r_slot];
    else if (r_is_data) r_word = r_mem_word;
    else                r_word = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcl_rvalid_o <= 1'b0;
      lcl_rdata_o  <= '0;
      rmt_rvalid_o <= 1'b0;
      rmt_rdata_o  <= '0;
    end else begin
      lcl_rvalid_o <= lcl_req_i & ~lcl_we_i;
      if (lcl_req_i && !lcl_we_i) lcl_rdata_o <= l_word;
      rmt_rvalid_o <= rmt_rd_i;
      if (rmt_rd_i) rmt_rdata_o <= r_word;
    end
  end
endmodule

// File: rtl/mbx_regfile_chk.sv
module mbx_regfile_chk #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned MSG_WORDS = 8,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W = SLOT_W + 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lcl_req_i,
  input logic                 lcl_we_i,
  input logic [ADDR_W-1:0]    lcl_addr_i,
  input logic                 lcl_rvalid_o,
  input logic [WORD_W-1:0]    lcl_rdata_o,
  input logic                 rmt_rd_i,
  input logic                 rmt_rvalid_o,
  input logic                 rmt_ack_i,
  input logic [SLOT_W-1:0]    rmt_ack_slot_i,
  input logic [NUM_SLOTS-1:0] ack_evt_o
);
  localparam logic [3:0] LAST_OFF = 4'(MSG_WORDS);

  p_evt_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_evt_o));

  p_evt_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_evt_o != '0) |-> $past(rmt_ack_i));

  p_evt_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmt_ack_i |=> (ack_evt_o == '0) || (ack_evt_o == (NUM_SLOTS'(1) << $past(rmt_ack_slot_i))));

  p_lcl_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcl_req_i && !lcl_we_i) |=> lcl_rvalid_o);

  p_lcl_rvalid_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcl_rvalid_o |-> $past(lcl_req_i && !lcl_we_i));

  p_rmt_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmt_rd_i |=> rmt_rvalid_o);

  p_unmapped_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcl_req_i && !lcl_we_i && ((lcl_addr_i[1:0] != 2'b00) || (lcl_addr_i[5:2] > LAST_OFF)))
    |=> (lcl_rdata_o == '0));
endmodule

bind mbx_regfile mbx_regfile_chk #(
  .NUM_SLOTS(NUM_SLOTS), .MSG_WORDS(MSG_WORDS), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/sim_mbx_regfile.sv
module sim_mbx_regfile;
  localparam int CLK_P = 10;
  localparam int NS    = 32;
  localparam int NW    = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lcl_req_i = 1'b0, lcl_we_i = 1'b0;
  logic [10:0] lcl_addr_i = '0;
  logic [31:0] lcl_wdata_i = '0;
  logic        lcl_rvalid_o;
  logic [31:0] lcl_rdata_o;
  logic        rmt_rd_i = 1'b0;
  logic [10:0] rmt_addr_i = '0;
  logic        rmt_rvalid_o;
  logic [31:0] rmt_rdata_o;
  logic        rmt_ack_i = 1'b0;
  logic [4:0]  rmt_ack_slot_i = '0;
  logic [31:0] ack_evt_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  mbx_regfile u0 (.*);

  function automatic logic [10:0] ad(int s, int off);
    return 11'(s * 64 + off);
  endfunction

  function automatic logic [31:0] dpat(int s, int w);
    return (32'(s) * 32'h0101_0101) ^ (32'(w) << 20) ^ 32'h5A00_0F0F;
  endfunction

  function automatic logic [31:0] mpat(int s);
    logic [31:0] v;
    v = 32'h5B00_0000 ^ (32'(s) << 12);
    v = v | 32'h20 | 32'(s % 2);
    if (s % 3 == 0) v = v | 32'hA00 | 32'h6;
    else v = v | 32'h8;
    return v & ~32'h1 | 32'(s % 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic lwr(logic [10:0] a, logic [31:0] d);
    @(negedge clk_i);
    lcl_req_i = 1; lcl_we_i = 1; lcl_addr_i = a; lcl_wdata_i = d;
    @(negedge clk_i);
    lcl_req_i = 0; lcl_we_i = 0;
  endtask

  task automatic lrd(logic [10:0] a, output logic [31:0] d, output logic v);
    @(negedge clk_i);
    lcl_req_i = 1; lcl_we_i = 0; lcl_addr_i = a;
    @(negedge clk_i);
    lcl_req_i = 0;
    d = lcl_rdata_o; v = lcl_rvalid_o;
  endtask

  task automatic rrd(logic [10:0] a, output logic [31:0] d, output logic v);
    @(negedge clk_i);
    rmt_rd_i = 1; rmt_addr_i = a;
    @(negedge clk_i);
    rmt_rd_i = 0;
    d = rmt_rdata_o; v = rmt_rvalid_o;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
  end

  initial begin
    logic [31:0] d;
    logic v;
    logic [31:0] m;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R6 reset state, R7 unmapped offsets
    chk("R6 evt", ack_evt_o, 32'h0);
    chk("R6 rvalid", {31'h0, lcl_rvalid_o}, 32'h0);
    for (int s = 0; s < NS; s++) begin
      for (int o = 0; o < 16; o++) begin
        lrd(ad(s, o * 4), d, v);
        if (o == 0) chk("R6 mode", d, 32'h10);
        else if (o <= NW) chk("R6 data", d, 32'h0);
        else chk("R7 reset unmapped", d, 32'h0);
      end
    end

    // R1 R2 data writes, readback on both ports
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) lwr(ad(s, 4 + 4 * w), dpat(s, w));
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        lrd(ad(s, 4 + 4 * w), d, v);
        chk("R1 R2 data", d, dpat(s, w));
        chk("R2 rvalid", {31'h0, v}, 32'h1);
        rrd(ad(s, 4 + 4 * w), d, v);
        chk("R8 data", d, dpat(s, w));
        chk("R8 rvalid", {31'h0, v}, 32'h1);
      end
    end

    // R3 mode words hold all bits
    for (int s = 0; s < NS; s++) lwr(ad(s, 0), mpat(s));
    for (int s = 0; s < NS; s++) begin
      lrd(ad(s, 0), d, v);
      chk("R3 mode", d, mpat(s));
      rrd(ad(s, 0), d, v);
      chk("R8 mode", d, mpat(s));
    end

    // R7 unmapped and misaligned writes ignored
    for (int s = 0; s < NS; s += 5) begin
      for (int o = NW + 1; o < 16; o++) lwr(ad(s, o * 4), 32'hFFFF_FFFF);
      lwr(ad(s, 1), 32'hDEAD_BEEF);
      lwr(ad(s, 6), 32'hDEAD_BEEF);
      for (int o = NW + 1; o < 16; o++) begin
        lrd(ad(s, o * 4), d, v);
        chk("R7 unmapped", d, 32'h0);
      end
      lrd(ad(s, 2), d, v);
      chk("R7 misaligned", d, 32'h0);
      lrd(ad(s, 0), d, v);
      chk("R7 mode kept", d, mpat(s));
      for (int w = 0; w < NW; w++) begin
        lrd(ad(s, 4 + 4 * w), d, v);
        chk("R7 data kept", d, dpat(s, w));
      end
    end

    // R4 R5 acknowledge in both styles
    for (int s = 0; s < NS; s++) begin
      @(negedge clk_i);
      rmt_ack_i = 1; rmt_ack_slot_i = 5'(s);
      chk("R5 no early evt", ack_evt_o, 32'h0);
      @(negedge clk_i);
      rmt_ack_i = 0;
      if (s % 2 == 1) chk("R4 no evt", ack_evt_o, 32'h0);
      else chk("R5 evt", ack_evt_o, 32'h1 << s);
      @(negedge clk_i);
      chk("R5 pulse ends", ack_evt_o, 32'h0);
      lrd(ad(s, 0), d, v);
      m = (mpat(s) & ~32'hF0) | ((s % 2 == 1) ? 32'h10 : 32'h80);
      if (s % 2 == 1) chk("R4 idle", d, m);
      else chk("R5 ackd", d, m);
    end

    // R9 same-cycle write and acknowledge
    lwr(ad(3, 0), 32'h0000_0020);
    @(negedge clk_i);
    lcl_req_i = 1; lcl_we_i = 1; lcl_addr_i = ad(3, 0); lcl_wdata_i = 32'h1234_5021;
    rmt_ack_i = 1; rmt_ack_slot_i = 5'd3;
    @(negedge clk_i);
    lcl_req_i = 0; lcl_we_i = 0; rmt_ack_i = 0;
    chk("R9 evt", ack_evt_o, 32'h8);
    lrd(ad(3, 0), d, v);
    chk("R9 mode", d, 32'h1234_5081);
    // now auto style stored: ack goes idle
    @(negedge clk_i);
    rmt_ack_i = 1; rmt_ack_slot_i = 5'd3;
    @(negedge clk_i);
    rmt_ack_i = 0;
    chk("R4 after R9 evt", ack_evt_o, 32'h0);
    lrd(ad(3, 0), d, v);
    chk("R4 after R9 mode", d, 32'h1234_5011);

    summary();
  end
endmodule